// File: doc/BRIEF.md
# Compare/Test Flag Register with Condition Evaluator

This block holds four status flags (carry, zero, sign, overflow) in a register. It produces them from one of two operations on a pair of 64-bit operands. A compare operation subtracts the second operand from the first and keeps only the flags. A test operation forms the bitwise AND of the operands and keeps only the flags. Operations that only move data or only compute an address pass through without touching the register. The write happens on a clock edge when the write enable is high.

A 4-bit condition selector is evaluated against the stored flags, combinationally and at all times. The result drives three outputs:

- a branch-taken bit,
- a set-on-condition byte,
- a conditional-move result that picks the source operand when the condition holds and the old destination value when it does not.

The signed conditions use sign, overflow and zero. The unsigned conditions use carry (borrow on subtraction) and zero. The block has no data stream, so every pin is a plain level signal with no handshake or back-pressure.

Top module: `cond_flag_unit`

## Requirements
- R1: While rst_n is low the flag register reads 0, so `flags_q` is 4'b0000 after reset.
- R2: With `op` = 0 (compare) and `flag_we` high, at the next rising edge the flags take these values, with `flags_q` bit order {overflow, sign, zero, carry} from bit 3 down to bit 0:
  - carry = 1 when `opnd_a` < `opnd_b` unsigned (borrow);
  - zero = 1 when `opnd_a` - `opnd_b` is 0;
  - sign = the difference's bit 63;
  - overflow = 1 on a two's-complement overflow of the subtraction.
- R3: With `op` = 1 (test) and `flag_we` high, at the next rising edge the flags take these values:
  - zero = 1 when `opnd_a` & `opnd_b` is 0;
  - sign = bit 63 of that AND;
  - carry and overflow are cleared to 0.
- R4: The flag register is unchanged across a rising edge in each of these cases:
  - `flag_we` is low;
  - `op` is 2 (move);
  - `op` is 3 (address computation).
- R5: These signed condition codes are evaluated on the stored flags:
  - 5 greater = (sign == overflow) and not zero;
  - 6 greater-or-equal = (sign == overflow);
  - 7 less = (sign != overflow);
  - 8 less-or-equal = zero or (sign != overflow).
- R6: These unsigned condition codes are evaluated on the stored flags:
  - 9 above = not carry and not zero;
  - 10 above-or-equal = not carry;
  - 11 below = carry;
  - 12 below-or-equal = carry or zero.
- R7: These remaining condition codes are evaluated on the stored flags:
  - 0 always = 1;
  - 1 equal = zero;
  - 2 not-equal = not zero;
  - 3 negative = sign;
  - 4 non-negative = not sign;
  - codes 13, 14 and 15 evaluate to 0.
- R8: `set_byte` is 8'h01 when the selected condition holds and 8'h00 otherwise, and `taken` equals the condition.
- R9: `cmov_out` equals `mov_src` when the selected condition holds and `mov_dst` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| flag_we | input | 1 | Flag write enable |
| op | input | 2 | Operation kind: 0 compare, 1 test, 2 move, 3 address |
| opnd_a | input | 64 | First operand (minuend for compare) |
| opnd_b | input | 64 | Second operand (subtrahend for compare) |
| cond_sel | input | 4 | Condition code, see R5 to R7 |
| mov_src | input | 64 | Conditional-move source value |
| mov_dst | input | 64 | Conditional-move old destination value |
| flags_q | output | 4 | Stored flags {overflow, sign, zero, carry} |
| taken | output | 1 | Selected condition holds |
| set_byte | output | 8 | Set-on-condition byte |
| cmov_out | output | 64 | Conditional-move result |

## Verification
The assertions check four properties on every cycle:
- the flags hold whenever no compare or test is written;
- a compare's carry and zero flags agree with an independent unsigned comparison of the operands;
- a test clears carry and overflow;
- the set byte and the move result always follow the taken bit.

The bench's scenarios are needed for the rest. They show the sign and overflow values at the signed wrap-around boundaries. They also show the full truth of all sixteen condition codes against each stored flag pattern, including the three unused codes. Finally, they show the reset value and that move and address operations leave a prior compare result intact.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

  localparam int unsigned CODE_W = 4;
  localparam int unsigned OP_W   = 2;

  localparam logic [OP_W-1:0] OP_CMP  = 2'd0;
  localparam logic [OP_W-1:0] OP_TEST = 2'd1;
  localparam logic [OP_W-1:0] OP_MOVE = 2'd2;
  localparam logic [OP_W-1:0] OP_ADDR = 2'd3;

  localparam logic [CODE_W-1:0] CC_ALWAYS = 4'd0;
  localparam logic [CODE_W-1:0] CC_EQ     = 4'd1;
  localparam logic [CODE_W-1:0] CC_NE     = 4'd2;
  localparam logic [CODE_W-1:0] CC_NEG    = 4'd3;
  localparam logic [CODE_W-1:0] CC_NNEG   = 4'd4;
  localparam logic [CODE_W-1:0] CC_GT     = 4'd5;
  localparam logic [CODE_W-1:0] CC_GE     = 4'd6;
  localparam logic [CODE_W-1:0] CC_LT     = 4'd7;
  localparam logic [CODE_W-1:0] CC_LE     = 4'd8;
  localparam logic [CODE_W-1:0] CC_ABOVE  = 4'd9;
  localparam logic [CODE_W-1:0] CC_AE     = 4'd10;
  localparam logic [CODE_W-1:0] CC_BELOW  = 4'd11;
  localparam logic [CODE_W-1:0] CC_BE     = 4'd12;

  typedef struct packed {
    logic ovf;
    logic neg;
    logic zero;
    logic carry;
  } flags_t;

  function automatic logic op_sets_flags(input logic [OP_W-1:0] kind);
    return (kind == OP_CMP) || (kind == OP_TEST);
  endfunction

endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flagcond_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output flags_t          nxt
);
  localparam int unsigned MSB = W - 1;

  logic [W:0]   diff;
  logic [W-1:0] land;

  assign diff = {1'b0, a} - {1'b0, b};
  assign land = a & b;

  always_comb begin
    nxt = '0;
    if (op == OP_TEST) begin
      nxt.zero = (land == '0);
      nxt.neg  = land[MSB];
    end else begin
      nxt.carry = diff[W];
      nxt.zero  = (diff[W-1:0] == '0);
      nxt.neg   = diff[MSB];
      nxt.ovf   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    end
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flagcond_pkg::*;
(
  input  flags_t            f,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic sgn_ok;
  assign sgn_ok = (f.neg == f.ovf);

  always_comb begin
    case (code)
      CC_ALWAYS: hit = 1'b1;
      CC_EQ:     hit = f.zero;
      CC_NE:     hit = !f.zero;
      CC_NEG:    hit = f.neg;
      CC_NNEG:   hit = !f.neg;
      CC_GT:     hit = sgn_ok && !f.zero;
      CC_GE:     hit = sgn_ok;
      CC_LT:     hit = !sgn_ok;
      CC_LE:     hit = f.zero || !sgn_ok;
      CC_ABOVE:  hit = !f.carry && !f.zero;
      CC_AE:     hit = !f.carry;
      CC_BELOW:  hit = f.carry;
      CC_BE:     hit = f.carry || f.zero;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import flagcond_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [OP_W-1:0]   op,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [CODE_W-1:0] cond_sel,
  input  logic [W-1:0]      mov_src,
  input  logic [W-1:0]      mov_dst,
  output logic [3:0]        flags_q,
  output logic              taken,
  output logic [7:0]        set_byte,
  output logic [W-1:0]      cmov_out
);
  flags_t flg_r;
  flags_t flg_nxt;
  logic   wr_en;

  flag_calc #(.W(W)) u_calc (
    .op (op),
    .a  (opnd_a),
    .b  (opnd_b),
    .nxt(flg_nxt)
  );

  assign wr_en = flag_we && op_sets_flags(op);

  always_ff @(posedge clk) begin
    if (!rst_n)     flg_r <= '0;
    else if (wr_en) flg_r <= flg_nxt;
  end

  cond_eval u_eval (
    .f   (flg_r),
    .code(cond_sel),
    .hit (taken)
  );

  assign flags_q  = flg_r;
  assign set_byte = {7'd0, taken};
  assign cmov_out = taken ? mov_src : mov_dst;

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && (op == OP_CMP || op == OP_TEST)) |=> $stable(flags_q)); // R4

  AST_CMP_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == OP_CMP) |=> (flags_q[0] == $past(opnd_a < opnd_b))); // R2

  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == OP_CMP) |=> (flags_q[1] == $past(opnd_a == opnd_b))); // R2

  AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == OP_TEST) |=> (!flags_q[0] && !flags_q[3])); // R3

  AST_SET_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_byte == (taken ? 8'h01 : 8'h00)); // R8

  AST_CMOV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmov_out == (taken ? mov_src : mov_dst)); // R9
endmodule

// File: tb/cond_flag_unit_test.sv
`timescale 1ns/1ps
module cond_flag_unit_test;
  localparam int W  = 64;
  localparam int NV = 9;
  localparam int VW = 2 + W + W + 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flag_we;
  logic [1:0]   op;
  logic [W-1:0] opnd_a, opnd_b, mov_src, mov_dst;
  logic [3:0]   cond_sel;
  logic [3:0]   flags_q;
  logic         taken;
  logic [7:0]   set_byte;
  logic [W-1:0] cmov_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cond_flag_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
    .mov_src(mov_src), .mov_dst(mov_dst), .flags_q(flags_q),
    .taken(taken), .set_byte(set_byte), .cmov_out(cmov_out)
  );

  // {op, a, b, expected flags {ovf, sign, zero, carry}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 64'd5, 64'd3, 4'b0000},
    {2'd0, 64'd3, 64'd5, 4'b0101},
    {2'd0, 64'd7, 64'd7, 4'b0010},
    {2'd0, 64'h8000_0000_0000_0000, 64'd1, 4'b1000},
    {2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1101},
    {2'd1, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_000F, 4'b0010},
    {2'd0, 64'd0, 64'd1, 4'b0101},
    {2'd1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 4'b0100},
    {2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'b0000}
  };

  function automatic logic exp_hit(input logic [3:0] f, input int c);
    logic cf, zf, sf, of;
    {of, sf, zf, cf} = f;
    case (c)
      0:  return 1'b1;
      1:  return zf;
      2:  return !zf;
      3:  return sf;
      4:  return !sf;
      5:  return (sf == of) && !zf;
      6:  return sf == of;
      7:  return sf != of;
      8:  return zf || (sf != of);
      9:  return !cf && !zf;
      10: return !cf;
      11: return cf;
      12: return cf || zf;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    if (c >= 5 && c <= 8)  return "R5";
    if (c >= 9 && c <= 12) return "R6";
    return "R7";
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sweep_conds(input logic [3:0] f);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond_sel = 4'(c);
      #1;
      chk(taken == exp_hit(f, c), tag_of(c), W'(taken), W'(exp_hit(f, c)));
      chk(set_byte == {7'd0, exp_hit(f, c)}, "R8", W'(set_byte), W'(exp_hit(f, c)));
      chk(cmov_out == (exp_hit(f, c) ? mov_src : mov_dst), "R9", cmov_out,
          exp_hit(f, c) ? mov_src : mov_dst);
    end
  endtask

  task automatic write_op(input logic [1:0] k, input logic [W-1:0] a, input logic [W-1:0] b, input logic we);
    @(negedge clk);
    op = k; opnd_a = a; opnd_b = b; flag_we = we;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flag_we = 1'b0; op = 2'd0; opnd_a = '0; opnd_b = '0;
    cond_sel = 4'd0; mov_src = 64'hAAAA_AAAA_AAAA_AAAA; mov_dst = 64'h5555_5555_5555_5555;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flags_q == 4'b0000, "R1", W'(flags_q), 0);
    chk(taken == 1'b1, "R7", W'(taken), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      write_op(v[VW-1 -: 2], v[VW-3 -: W], v[4 +: W], 1'b1);
      chk(flags_q == v[3:0], (v[VW-1 -: 2] == 2'd0) ? "R2" : "R3", W'(flags_q), W'(v[3:0]));
      sweep_conds(v[3:0]);
    end

    // R4: load a known pattern, then try operations that must not write
    write_op(2'd0, 64'd3, 64'd5, 1'b1);
    chk(flags_q == 4'b0101, "R2", W'(flags_q), 4'b0101);
    write_op(2'd2, 64'd7, 64'd7, 1'b1);
    chk(flags_q == 4'b0101, "R4 move", W'(flags_q), 4'b0101);
    write_op(2'd3, 64'd9, 64'd9, 1'b1);
    chk(flags_q == 4'b0101, "R4 address", W'(flags_q), 4'b0101);
    write_op(2'd0, 64'd7, 64'd7, 1'b0);
    chk(flags_q == 4'b0101, "R4 enable low", W'(flags_q), 4'b0101);
    write_op(2'd1, 64'd0, 64'd0, 1'b0);
    chk(flags_q == 4'b0101, "R4 test enable low", W'(flags_q), 4'b0101);

    // R1: reset again clears a non-zero pattern
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(flags_q == 4'b0000, "R1 re-reset", W'(flags_q), 0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule